// File: doc/BRIEF.md
# Write-Masked GPIO Port Register Block

This block holds the output-value and direction state of a 32-pin general-purpose I/O port and exposes it on a simple memory-mapped bus. Each 32-bit logical register is split across two consecutive bus words. The first word covers pins 0 to 15 and the second covers pins 16 to 31. In every write, the upper sixteen bits of the bus data are per-bit enables for the lower sixteen. Software can therefore set or clear any group of pins in a single write, with no read-modify-write and no lock.

Reads return the stored half in bits 15:0, with zeros in bits 31:16. A read-only word returns the live level of all 32 pins after a two-flop synchronizer. A second read-only word returns a fixed version identifier. The stored registers drive the pad output-value and output-enable lines directly from flops.

The bus uses word addresses: word index n corresponds to byte offset 4*n. The map is:

| Word | Contents |
|------|----------|
| 0 | output value, pins 15:0 |
| 1 | output value, pins 31:16 |
| 2 | direction, pins 15:0 |
| 3 | direction, pins 31:16 |
| 4 | synchronized pin levels, all 32 pins |
| 5 | version identifier |

Every other word is unmapped.

Top module: `gpio_wm_port`

## Requirements
- R1: While `rst` is high and after its release, `pad_out`, `pad_oe` and `bus_rdata` are all 0, which makes every pin an input driving 0.
- R2: A write to word 0 sets output-value bit k (k = 0..15) to `bus_wdata[k]` only when `bus_wdata[16+k]` is 1. Every other bit keeps its value.
- R3: Words 1 and 3 apply the same masked write to pins 16..31: bus bit k maps to pin 16+k. Words 0 and 2 never touch pins 16..31.
- R4: A read of words 0 to 3 returns the 16 stored bits of that half in `bus_rdata[15:0]` and 0 in `bus_rdata[31:16]`, one cycle after the request.
- R5: Direction bit k set to 1 drives `pad_oe[k]` high, which makes pin k an output. Direction bit k set to 0 makes pin k an input. The direction register occupies words 2 and 3.
- R6: A read of word 4 returns `pin_in` delayed by two synchronizer flops. A read sampled on the first clock edge after a pin change still returns the old level. The new level is returned once the change has passed both flops.
- R7: A read of word 5 returns the version identifier 0x01000C2B. Major version is in bits 31:24, minor version in bits 23:16, and revision in bits 15:0.
- R8: Writes to words 4, 5 or any unmapped word change neither `pad_out` nor `pad_oe`. A read of an unmapped word returns 0.
- R9: A write whose enable half is all zero leaves the addressed half unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data: bits 31:16 enables, bits 15:0 values |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The assertions check the following on every cycle:
- a stored half changes only in bits whose enable was set, and not at all when no enable was set;
- writes to read-only or unmapped words leave the pads untouched;
- half-word reads carry zeros in their upper bits;
- version reads return the identifier.

Only the bench's scenarios can show the rest:
- the exact values assembled from several masked writes;
- the mapping of the upper word to pins 16 to 31;
- the two-cycle latency of the pin synchronizer;
- the reset state.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;
  localparam int unsigned PINS   = 32;
  localparam int unsigned HALF_W = PINS / 2;
  localparam int unsigned WORD_AW = 3;

  localparam logic [WORD_AW-1:0] WD_OUT_LO = 3'd0;
  localparam logic [WORD_AW-1:0] WD_OUT_HI = 3'd1;
  localparam logic [WORD_AW-1:0] WD_DIR_LO = 3'd2;
  localparam logic [WORD_AW-1:0] WD_DIR_HI = 3'd3;
  localparam logic [WORD_AW-1:0] WD_PINS   = 3'd4;
  localparam logic [WORD_AW-1:0] WD_VER    = 3'd5;

  localparam logic [31:0] VERSION_ID = 32'h0100_0C2B;
endpackage

// File: rtl/gpio_wm_half.sv
module gpio_wm_half #(
  parameter int unsigned HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2*HW-1:0] wdata,
  output logic [HW-1:0]   q
);
  logic [HW-1:0] en_bits;
  logic [HW-1:0] val_bits;

  assign en_bits  = wdata[2*HW-1:HW];
  assign val_bits = wdata[HW-1:0];

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= (q & ~en_bits) | (val_bits & en_bits);
  end

  // R2: only enabled bits may change
  a_r2_masked_only: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (((q ^ $past(q)) & ~$past(en_bits)) == '0));

  // R9: no write or an empty enable field keeps the half intact
  a_r9_no_enable_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (en_bits == '0)) |=> $stable(q));
endmodule

// File: rtl/gpio_wm_sync.sv
module gpio_wm_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_wm_port.sv
module gpio_wm_port
  import gpio_wm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] VERSION     = VERSION_ID
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [WORD_AW-1:0] bus_word,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [PINS-1:0]    pin_in,
  output logic [PINS-1:0]    pad_out,
  output logic [PINS-1:0]    pad_oe
);
  localparam int unsigned NHALF = 4;

  logic [HALF_W-1:0] half_q [NHALF];
  logic [PINS-1:0]   pins_sync;
  logic [31:0]       rd_val;
  logic              wr_cyc;
  logic              rd_cyc;

  assign wr_cyc = bus_sel && bus_wr;
  assign rd_cyc = bus_sel && !bus_wr;

  for (genvar i = 0; i < NHALF; i++) begin : g_half
    gpio_wm_half #(.HW(HALF_W)) u_half (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_cyc && (bus_word == WORD_AW'(i))),
      .wdata (bus_wdata),
      .q     (half_q[i])
    );
  end

  assign pad_out = {half_q[1], half_q[0]};
  assign pad_oe  = {half_q[3], half_q[2]};

  gpio_wm_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_sync)
  );

  always_comb begin
    rd_val = '0;
    case (bus_word)
      WD_OUT_LO: rd_val = {16'h0, half_q[0]};
      WD_OUT_HI: rd_val = {16'h0, half_q[1]};
      WD_DIR_LO: rd_val = {16'h0, half_q[2]};
      WD_DIR_HI: rd_val = {16'h0, half_q[3]};
      WD_PINS:   rd_val = pins_sync;
      WD_VER:    rd_val = VERSION;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_cyc) bus_rdata <= rd_val;
  end

  // R8: writes outside the four stored words leave the pads alone
  a_r8_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc && (bus_word > WD_DIR_HI)) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R4: half-word reads carry zeros above bit 15
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_cyc && (bus_word <= WD_DIR_HI)) |=> (bus_rdata[31:16] == 16'h0));

  // R7: version word
  a_r7_version: assert property (@(posedge clk) disable iff (rst)
    (rd_cyc && (bus_word == WD_VER)) |=> (bus_rdata == VERSION));
endmodule

// File: tb/gpio_wm_port_bench.sv
module gpio_wm_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_wm_port u_gpio_wm_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // entry: {word[2:0], write data, expected read-back of that word}
  localparam int NVEC = 7;
  localparam logic [66:0] VEC [NVEC] = '{
    {3'd0, 32'hFFFF_A5A5, 32'h0000_A5A5},  // R2 full write
    {3'd0, 32'h000F_FFFF, 32'h0000_A5AF},  // R2 set low nibble only
    {3'd0, 32'h8000_0000, 32'h0000_25AF},  // R2 clear bit 15 only
    {3'd1, 32'hFFFF_1234, 32'h0000_1234},  // R3 upper half
    {3'd1, 32'h0000_FFFF, 32'h0000_1234},  // R9 empty enable field
    {3'd2, 32'h00FF_00F0, 32'h0000_00F0},  // R5 direction low
    {3'd3, 32'h8001_8001, 32'h0000_8001}   // R5 direction high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = w;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    check("R1 pad_out in reset", pad_out, 32'h0);
    check("R1 pad_oe in reset", pad_oe, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    bus_read(3'd2, rv);
    check("R1 direction reads 0", rv, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][66:64], VEC[i][63:32]);
      bus_read(VEC[i][66:64], rv);
      check("R2/R3/R4/R5/R9 table read-back", rv, VEC[i][31:0]);
    end

    check("R3 pad_out assembled", pad_out, 32'h1234_25AF);
    check("R5 pad_oe assembled", pad_oe, 32'h8001_00F0);

    bus_write(3'd4, 32'hFFFF_FFFF);
    bus_write(3'd5, 32'hFFFF_0000);
    bus_write(3'd7, 32'hFFFF_FFFF);
    check("R8 pad_out after ro writes", pad_out, 32'h1234_25AF);
    check("R8 pad_oe after ro writes", pad_oe, 32'h8001_00F0);
    bus_read(3'd6, rv);
    check("R8 unmapped read", rv, 32'h0);

    bus_read(3'd5, rv);
    check("R7 version", rv, 32'h0100_0C2B);

    // R6: change pins, read sampled on the very next edge returns old level
    @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = 3'd4;
    @(negedge clk);
    bus_sel = 1'b0;
    check("R6 sync latency old level", bus_rdata, 32'h0);
    repeat (2) @(negedge clk);
    bus_read(3'd4, rv);
    check("R6 synced level", rv, 32'hDEAD_BEEF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule